// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block runs read cycles on an external asynchronous memory bus (SRAM, NOR flash, simple peripherals). A host presents a request with a word address, a chip-select index and a device width. The block lowers the matching chip select, drives the word address and the byte offset, pulses the output enable and captures the data bus. It then returns one 32-bit word with a one-cycle valid pulse.

Each bus operation has a setup, a strobe and a hold phase. Their lengths come from a per-chip-select timing word, which is latched when the request is accepted. A device 8 or 16 bits wide needs several operations per word. These run back to back with the chip select held low, and the bytes are assembled little-endian. A wait input, synchronised and of programmable polarity, can stretch the strobe. When another request is already waiting as a word completes, a programmable turnaround gap with every chip select high comes before it.

Per chip select `k`, the timing word is `cfg_rd[16*k +: 16]`. Its fields are: bits [3:0] setup, [9:4] strobe, [12:10] hold, [14:13] turnaround, and bit [15] wait polarity (1 = wait active high). A field value N gives N+1 cycles. The device width code is 0 = 8 bit, 1 = 16 bit, 2 = 32 bit.

Top module: `async_rd_seq`

## Requirements
- R1: After reset, all `mem_cs_n` bits and `mem_oe_n` are high, and `rd_valid` is low.
- R2: For each operation, chip select is low for exactly (setup+1) cycles before `mem_oe_n` falls. Only the bit of the requested chip select is low, `mem_addr` carries the request's word address, and the phase lengths come from that chip select's timing word.
- R3: `mem_oe_n` is low for exactly (strobe+1) cycles per operation when wait is inactive. The data bus is captured on the edge that ends this window.
- R4: Each cycle that the wait input, after two flops of synchronisation, is seen active during the strobe extends the strobe by one cycle. Polarity bit 15 selects active-high (1) or active-low (0).
- R5: The wait input has no effect outside the strobe phase: the hold length stays (hold+1) while wait is active during hold.
- R6: After `mem_oe_n` rises, chip select and address stay valid for exactly (hold+1) cycles.
- R7: A width code of 0 gives 4 operations with `mem_sub` = 0,1,2,3 and data taken from `mem_data[7:0]`. Code 1 gives 2 operations with `mem_sub` = 0,2 and data from `mem_data[15:0]`. Code 2 gives one operation with `mem_sub` = 0. Pieces are placed little-endian, the lowest offset in the lowest byte.
- R8: Between the operations of one word, chip select stays low with no idle cycle, and the next setup starts directly after the hold.
- R9: The timing latched at acceptance is used for every operation of that word. A change to `cfg_rd` after acceptance does not alter them.
- R10: If `req_valid` is high when a word's last hold ends, all chip selects stay high for exactly (turnaround+1) cycles before the next setup. Otherwise the block goes idle, and a new request's chip select falls in the cycle after the edge on which `req_ready` was high.
- R11: `rd_valid` is high for exactly one cycle, in the cycle after the final hold, with the assembled word on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request pending, held until accepted |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | AW | Word address |
| req_cs | input | 2 | Chip-select index |
| req_width | input | 2 | Device width code |
| cfg_rd | input | 16*NCS | Per-chip-select read timing words |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | AW | Word address to the device |
| mem_sub | output | 2 | Byte offset within the word |
| mem_data | input | 32 | Device data bus |
| mem_wait | input | 1 | Device wait request |
| rd_valid | output | 1 | Word complete pulse |
| rd_data | output | 32 | Assembled word |

## Verification
Reads are issued at all three widths with different timing words on different chip selects. Phase counts that differ per field show whether the right field and the right chip select were used. Garbage on the unused data lanes and a byte pattern that depends on the address expose a wrong lane or wrong byte order. Wait is asserted for a fixed run in both polarities to measure the exact strobe extension, and again during hold to show it is ignored there. The timing word is rewritten in the middle of a byte-wide read, and back-to-back requests are compared with requests from idle to separate the turnaround gap from the direct start.

// File: rtl/async_rd_seq.sv
module async_rd_seq #(
  parameter int AW  = 20,
  parameter int NCS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_cs,
  input  logic [1:0]        req_width,
  input  logic [16*NCS-1:0] cfg_rd,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_sub,
  input  logic [31:0]       mem_data,
  input  logic              mem_wait,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  typedef enum logic [2:0] {IDLE, SETUP, STROBE, HOLD, TURN} st_t;

  st_t          st;
  logic [5:0]   cnt;
  logic [3:0]   t_su;
  logic [5:0]   t_st;
  logic [2:0]   t_ho;
  logic [1:0]   t_ta;
  logic         pol;
  logic [1:0]   cs_q;
  logic [AW-1:0] addr_q;
  logic [1:0]   wid_q;
  logic [1:0]   beat;
  logic [31:0]  acc;
  logic         w1, w2;

  wire [15:0] cfg_sel = cfg_rd[req_cs*16 +: 16];
  wire        wact    = pol ? w2 : ~w2;
  wire        busy    = (st == SETUP) || (st == STROBE) || (st == HOLD);
  wire        last    = wid_q[1] || (wid_q == 2'd1 && beat == 2'd1) || (beat == 2'd3);
  wire        accept  = req_valid && (st == IDLE || (st == TURN && cnt == 6'd0));

  assign req_ready = accept;
  assign mem_oe_n  = (st != STROBE);
  assign mem_cs_n  = busy ? ~(NCS'(1) << cs_q) : '1;
  assign mem_addr  = busy ? addr_q : '0;
  assign mem_sub   = wid_q[1] ? 2'd0 : (wid_q == 2'd1) ? {beat[0], 1'b0} : beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= 1'b0;
      w2 <= 1'b0;
    end else begin
      w1 <= mem_wait;
      w2 <= w1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      t_su     <= '0;
      t_st     <= '0;
      t_ho     <= '0;
      t_ta     <= '0;
      pol      <= 1'b1;
      cs_q     <= '0;
      addr_q   <= '0;
      wid_q    <= '0;
      beat     <= '0;
      acc      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        st     <= SETUP;
        cnt    <= {2'b0, cfg_sel[3:0]};
        t_su   <= cfg_sel[3:0];
        t_st   <= cfg_sel[9:4];
        t_ho   <= cfg_sel[12:10];
        t_ta   <= cfg_sel[14:13];
        pol    <= cfg_sel[15];
        cs_q   <= req_cs;
        addr_q <= req_addr;
        wid_q  <= req_width;
        beat   <= '0;
        acc    <= '0;
      end else begin
        case (st)
          SETUP:
            if (cnt == 6'd0) begin
              st  <= STROBE;
              cnt <= t_st;
            end else cnt <= cnt - 6'd1;
          STROBE:
            if (!wact) begin
              if (cnt == 6'd0) begin
                case (wid_q)
                  2'd0:    acc[beat*8 +: 8]     <= mem_data[7:0];
                  2'd1:    acc[beat[0]*16 +: 16] <= mem_data[15:0];
                  default: acc                  <= mem_data;
                endcase
                st  <= HOLD;
                cnt <= {3'b0, t_ho};
              end else cnt <= cnt - 6'd1;
            end
          HOLD:
            if (cnt == 6'd0) begin
              if (!last) begin
                st   <= SETUP;
                cnt  <= {2'b0, t_su};
                beat <= beat + 2'd1;
              end else begin
                rd_valid <= 1'b1;
                rd_data  <= acc;
                st       <= req_valid ? TURN : IDLE;
                cnt      <= {4'b0, t_ta};
              end
            end else cnt <= cnt - 6'd1;
          TURN:
            if (cnt == 6'd0) st <= IDLE;
            else cnt <= cnt - 6'd1;
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  // R3
  oe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_cs_n != '1));

  // R4
  wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STROBE && wact) |=> (st == STROBE && $stable(cnt)));

  // R8
  beat_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && cnt == 6'd0 && !last) |=> (st == SETUP && $stable(mem_cs_n)));

  // R10
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TURN) |-> (mem_cs_n == '1 && mem_oe_n));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/async_rd_seq_test.sv
`timescale 1ns/1ps
module async_rd_seq_test;
  localparam int AW = 20;
  localparam int NCS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_cs = '0;
  logic [1:0] req_width = '0;
  logic [16*NCS-1:0] cfg_rd = '0;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_sub;
  logic [31:0] mem_data;
  logic mem_wait = 1'b0;
  logic rd_valid;
  logic [31:0] rd_data;
  int dev_w = 2;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  async_rd_seq #(.AW(AW), .NCS(NCS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cs(req_cs), .req_width(req_width), .cfg_rd(cfg_rd),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_sub(mem_sub),
    .mem_data(mem_data), .mem_wait(mem_wait), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] bv(logic [AW-1:0] a, int off);
    return a[7:0] ^ 8'(off * 8'h35) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] word_of(logic [AW-1:0] a);
    return {bv(a, 3), bv(a, 2), bv(a, 1), bv(a, 0)};
  endfunction

  function automatic logic [15:0] mk(int su, int st, int ho, int ta, bit p);
    return {p, 2'(ta), 3'(ho), 6'(st), 4'(su)};
  endfunction

  always_comb begin
    if (dev_w == 0)      mem_data = {24'hAAAAAA, bv(mem_addr, int'(mem_sub))};
    else if (dev_w == 1) mem_data = {16'h5555, bv(mem_addr, int'(mem_sub) + 1), bv(mem_addr, int'(mem_sub))};
    else                 mem_data = word_of(mem_addr);
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(int cs, logic [AW-1:0] a, int wid);
    req_cs = 2'(cs);
    req_addr = a;
    req_width = 2'(wid);
    req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic observe(int cs, logic [AW-1:0] a, int wid, int esu, int est, int eho,
                         int wmode, bit p);
    int nb = (wid == 0) ? 4 : (wid == 1) ? 2 : 1;
    logic [3:0] ecs = ~(4'b1 << cs);
    for (int b = 0; b < nb; b++) begin
      int su = 0, stb = 0, ho = 0;
      int esub = (wid == 0) ? b : (wid == 1) ? 2 * b : 0;
      check(mem_cs_n == ecs, "R2", "chip select", mem_cs_n, ecs);
      check(mem_addr == a, "R2", "address", mem_addr, a);
      check(mem_sub == 2'(esub), "R7", "byte offset", mem_sub, esub);
      while (mem_oe_n && mem_cs_n == ecs) begin su++; @(negedge clk); end
      check(su == esu, "R2", "setup cycles", su, esu);
      while (!mem_oe_n) begin
        stb++;
        if (wmode == 1 && b == 0 && stb == 1) mem_wait = p;
        if (wmode == 1 && b == 0 && stb == 7) mem_wait = ~p;
        @(negedge clk);
      end
      if (wmode == 1 && b == 0) check(stb == est + 6, "R4", "stretched strobe", stb, est + 6);
      else check(stb == est, "R3", "strobe cycles", stb, est);
      while (mem_oe_n && mem_cs_n == ecs && mem_sub == 2'(esub)) begin
        ho++;
        if (wmode == 2 && ho == 1) mem_wait = p;
        @(negedge clk);
      end
      if (wmode == 2) begin
        mem_wait = ~p;
        check(ho == eho, "R5", "hold with wait active", ho, eho);
      end else check(ho == eho, "R6", "hold cycles", ho, eho);
      if (b < nb - 1) check(mem_cs_n == ecs, "R8", "chip select between beats", mem_cs_n, ecs);
    end
    check(mem_cs_n == 4'hF, "R10", "chip select released", mem_cs_n, 4'hF);
    check(rd_valid == 1'b1, "R11", "valid pulse", rd_valid, 1);
    check(rd_data == word_of(a), "R7", "assembled word", rd_data, word_of(a));
  endtask

  task automatic finish_idle();
    @(negedge clk);
    check(rd_valid == 1'b0, "R11", "valid one cycle", rd_valid, 0);
    check(req_ready == 1'b0, "R10", "idle without request", req_ready, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(mem_cs_n == 4'hF, "R1", "reset chip selects", mem_cs_n, 4'hF);
    check(mem_oe_n == 1'b1, "R1", "reset output enable", mem_oe_n, 1);
    check(rd_valid == 1'b0, "R1", "reset valid", rd_valid, 0);
  endtask

  task automatic t_word32();
    dev_w = 2;
    cfg_rd[16 +: 16] = mk(2, 3, 1, 0, 1'b1);
    issue(1, 20'h12345, 2);
    observe(1, 20'h12345, 2, 3, 4, 2, 0, 1'b1);
    finish_idle();
  endtask

  task automatic t_byte8();
    dev_w = 0;
    cfg_rd[32 +: 16] = mk(1, 2, 2, 0, 1'b1);
    issue(2, 20'h0ABCD, 0);
    cfg_rd[32 +: 16] = mk(5, 7, 6, 0, 1'b1);  // R9: rewritten after acceptance
    observe(2, 20'h0ABCD, 0, 2, 3, 3, 0, 1'b1);
    finish_idle();
  endtask

  task automatic t_half16();
    dev_w = 1;
    cfg_rd[0 +: 16] = mk(0, 0, 0, 0, 1'b1);
    issue(0, 20'hFFF0F, 1);
    observe(0, 20'hFFF0F, 1, 1, 1, 1, 0, 1'b1);
    finish_idle();
  endtask

  task automatic t_wait(bit p);
    dev_w = 2;
    mem_wait = ~p;
    cfg_rd[48 +: 16] = mk(1, 3, 1, 0, p);
    repeat (3) @(negedge clk);
    issue(3, p ? 20'h00777 : 20'h31415, 2);
    observe(3, p ? 20'h00777 : 20'h31415, 2, 2, 4, 2, 1, p);
    finish_idle();
  endtask

  task automatic t_wait_hold();
    dev_w = 2;
    mem_wait = 1'b0;
    cfg_rd[16 +: 16] = mk(1, 2, 4, 0, 1'b1);
    issue(1, 20'h2468A, 2);
    observe(1, 20'h2468A, 2, 2, 3, 5, 2, 1'b1);
    finish_idle();
  endtask

  task automatic t_back2back();
    int gap = 0;
    dev_w = 2;
    mem_wait = 1'b0;
    cfg_rd[16 +: 16] = mk(1, 1, 1, 2, 1'b1);
    cfg_rd[0 +: 16]  = mk(0, 2, 0, 3, 1'b1);
    issue(1, 20'h11111, 2);
    req_cs = 2'd0;
    req_addr = 20'h22222;
    req_width = 2'd2;
    req_valid = 1'b1;
    observe(1, 20'h11111, 2, 2, 2, 2, 0, 1'b1);
    while (mem_cs_n == 4'hF) begin gap++; @(negedge clk); end
    req_valid = 1'b0;
    check(gap == 3, "R10", "turnaround cycles", gap, 3);
    observe(0, 20'h22222, 2, 1, 3, 1, 0, 1'b1);
    finish_idle();
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_word32();
    t_byte8();
    t_half16();
    t_wait(1'b1);
    t_wait(1'b0);
    mem_wait = 1'b0;
    repeat (3) @(negedge clk);
    t_wait_hold();
    t_back2back();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule